// File: doc/BRIEF.md
# Variable-Page-Size Data Translation Lookaside Buffer

This block is a fully associative data translation buffer. It maps 64-bit virtual addresses to 41-bit physical addresses. Every slot holds a virtual page tag, a 13-bit address-space context, a physical frame, a 2-bit page-size code and seven attribute flags. The page size code picks 8 KB, 64 KB, 512 KB or 4 MB pages. A load/store unit presents one lookup per cycle: an address, a context, an access kind, a user/supervisor flag and a context-type code for fault reporting. The result is registered and comes back one cycle later as exactly one outcome: a hit, a miss, a data fault or a write-protection fault.

A hit returns the physical address together with byte-swap and writable flags, and marks the slot as used. A fault loads the fault status and fault address registers. Several fault causes can be flagged in the status at once. A miss or any fault loads the tag-access register, which replacement software uses to fill the buffer. Slots are written through a simple indexed fill port. Choosing which slot to replace is left to the surrounding logic.

Top module: `pgcam_tlb`

## Requirements
- R1: A lookup sampled with `reqValid` high at a rising edge gives its outcome on `rspValid`/`rspHit`/`rspMiss`/`rspFault`/`rspProt` after that edge. Exactly one outcome flag is set. `rspValid` is low in any cycle that follows a cycle with no request.
- R2: The page size code in `fillSize` sets how many low address bits are page offset: 0 gives 13 bits (8 KB), 1 gives 16 bits (64 KB), 2 gives 19 bits (512 KB) and 3 gives 22 bits (4 MB). A slot matches only when the address bits above the offset equal its tag.
- R3: A slot without the global flag (`fillAttr[1]`) matches only when its context equals `reqCtx`. A global slot matches under any context.
- R4: On a hit, `rspPa` takes the frame bits above the page offset and the virtual address bits inside the offset. The result is truncated to 41 bits, and bits 12:0 are always zero.
- R5: When several slots match, the slot with the lowest index gives the result.
- R6: A user access (`reqUser`=1) to a slot with the privileged flag (`fillAttr[2]`) is a data fault and sets status bit 6.
- R7: A non-faulting load (`reqKind`=2) to a slot with the side-effect flag (`fillAttr[4]`) sets status bit 7. Any other access kind to a slot with the no-fault-only flag (`fillAttr[5]`) sets status bit 8. Both are data faults, and bits 6 to 8 may be set together.
- R8: A store (`reqKind`=1) to a slot without the writable flag (`fillAttr[3]`) that has no data-fault cause gives `rspProt`, not `rspFault`. The status is loaded with bits 8:6 clear. A data-fault cause takes precedence over a protection fault.
- R9: Each data or protection fault loads `faultStatus`: bit 0 valid = 1, bit 1 overflow = the previous valid bit, bit 2 = store, bit 3 = supervisor (not `reqUser`), bits 5:4 = `reqCtxType`. It also loads `faultAddr` with `reqVa`. `fsrClear` zeroes the status in a cycle that has no fault.
- R10: A miss or fault loads `tagAccess` with `reqVa` with bits 12:0 cleared, ORed with `reqCtx`. A miss leaves `faultStatus` and `faultAddr` unchanged.
- R11: A clean hit sets the matched slot's bit in `entryUsed`, drives `rspSwap` from the invert-endian flag (`fillAttr[6]`) and drives `rspWritable` from the writable flag. A fill clears the filled slot's used bit.
- R12: A slot whose valid flag (`fillAttr[0]`) is clear never matches. A fill on `fillIdx` replaces every field of that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fillEn | input | 1 | Write one slot this cycle |
| fillIdx | input | IDX_W | Slot to write |
| fillVa | input | VA_W | Virtual page tag |
| fillCtx | input | CTX_W | Slot context |
| fillPa | input | PA_W | Physical frame |
| fillSize | input | 2 | Page size code |
| fillAttr | input | 7 | Flags: 0 valid, 1 global, 2 privileged, 3 writable, 4 side-effect, 5 no-fault-only, 6 invert-endian |
| reqValid | input | 1 | Lookup request |
| reqVa | input | VA_W | Lookup virtual address |
| reqCtx | input | CTX_W | Lookup context |
| reqKind | input | 2 | 0 load, 1 store, 2 non-faulting load |
| reqUser | input | 1 | User-mode access |
| reqCtxType | input | 2 | Context type recorded on fault |
| fsrClear | input | 1 | Clear fault status |
| rspValid | output | 1 | Registered result valid |
| rspHit | output | 1 | Clean hit |
| rspMiss | output | 1 | No matching slot |
| rspFault | output | 1 | Data fault |
| rspProt | output | 1 | Write-protection fault |
| rspPa | output | PA_W | Physical address on hit |
| rspSwap | output | 1 | Byte swap required |
| rspWritable | output | 1 | Page is writable |
| faultStatus | output | 9 | Fault status register |
| faultAddr | output | VA_W | Fault address register |
| tagAccess | output | VA_W | Tag-access register |
| entryUsed | output | ENTRIES | Per-slot used bits |

## Verification
The bench probes each page size just inside and just outside its boundary. A mask built from the wrong size code either misses a legal offset or hits the neighbouring page. It checks that global slots match under a foreign context while private ones miss, and that a fully set frame still yields a 41-bit address with clear low bits. It places two matching slots to catch a priority encoder that picks the highest index. It also combines privileged, side-effect and no-fault-only flags on one slot, which would expose a design that reports only the first cause, ranks protection above a data fault, or loses the overflow bit on a second unacknowledged fault.

// File: rtl/pgcam_pkg.sv
package pgcam_pkg;

  localparam int OFS_W  = 13;
  localparam int ATTR_W = 7;
  localparam int STAT_W = 9;

  localparam int A_VALID  = 0;
  localparam int A_GLOBAL = 1;
  localparam int A_PRIV   = 2;
  localparam int A_WR     = 3;
  localparam int A_SE     = 4;
  localparam int A_NFO    = 5;
  localparam int A_IE     = 6;

  typedef enum logic [1:0] {
    KIND_LOAD   = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_NFLOAD = 2'd2
  } accKind_t;

  // strobes from control to datapath, valid in the cycle of a request
  typedef struct packed {
    logic capture;
    logic rspHit;
    logic setUsed;
    logic loadFar;
    logic loadTag;
  } strobe_t;

endpackage

// File: rtl/pgcam_dpath.sv
module pgcam_dpath import pgcam_pkg::*; #(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 64,
  parameter int PA_W    = 41,
  parameter int CTX_W   = 13,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillEn,
  input  logic [IDX_W-1:0]   fillIdx,
  input  logic [VA_W-1:0]    fillVa,
  input  logic [CTX_W-1:0]   fillCtx,
  input  logic [PA_W-1:0]    fillPa,
  input  logic [1:0]         fillSize,
  input  logic [ATTR_W-1:0]  fillAttr,
  input  logic [VA_W-1:0]    reqVa,
  input  logic [CTX_W-1:0]   reqCtx,
  input  strobe_t            st,
  output logic               hitAny,
  output logic [ATTR_W-1:0]  hitAttr,
  output logic [PA_W-1:0]    rspPa,
  output logic               rspSwap,
  output logic               rspWritable,
  output logic [VA_W-1:0]    faultAddr,
  output logic [VA_W-1:0]    tagAccess,
  output logic [ENTRIES-1:0] entryUsed
);

  logic [VA_W-1:0]   tagQ  [ENTRIES];
  logic [CTX_W-1:0]  ctxQ  [ENTRIES];
  logic [PA_W-1:0]   paQ   [ENTRIES];
  logic [1:0]        szQ   [ENTRIES];
  logic [ATTR_W-1:0] attrQ [ENTRIES];
  logic [ENTRIES-1:0] usedQ;
  logic [ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]  selIdx;
  logic [VA_W-1:0]   selMask;
  logic [PA_W-1:0]   paNext;

  function automatic logic [VA_W-1:0] pageMaskF(input logic [1:0] sz);
    logic [VA_W-1:0] span;
    span = VA_W'(1) << (OFS_W + 3 * int'(sz));
    return ~(span - VA_W'(1));
  endfunction

  // slot storage: only the flags need a reset value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) attrQ[i] <= '0;
    end else if (fillEn) begin
      attrQ[fillIdx] <= fillAttr;
    end
  end

  always_ff @(posedge clk) begin
    if (fillEn) begin
      tagQ[fillIdx] <= fillVa;
      ctxQ[fillIdx] <= fillCtx;
      paQ[fillIdx]  <= fillPa;
      szQ[fillIdx]  <= fillSize;
    end
  end

  // parallel masked compare, one comparator per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    logic [VA_W-1:0] slotMask;
    always_comb slotMask = pageMaskF(szQ[g]);
    assign matchVec[g] = attrQ[g][A_VALID]
                       && (attrQ[g][A_GLOBAL] || (ctxQ[g] == reqCtx))
                       && ((reqVa & slotMask) == (tagQ[g] & slotMask));
  end

  // lowest index wins
  always_comb begin
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) selIdx = IDX_W'(i);
    end
  end

  assign hitAny  = |matchVec;
  assign hitAttr = attrQ[selIdx];
  assign selMask = pageMaskF(szQ[selIdx]);

  always_comb begin
    paNext = (paQ[selIdx] & selMask[PA_W-1:0]) | (reqVa[PA_W-1:0] & ~selMask[PA_W-1:0]);
    paNext[OFS_W-1:0] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPa       <= '0;
      rspSwap     <= 1'b0;
      rspWritable <= 1'b0;
      faultAddr   <= '0;
      tagAccess   <= '0;
      usedQ       <= '0;
    end else begin
      if (st.capture) begin
        rspPa       <= st.rspHit ? paNext : '0;
        rspSwap     <= st.rspHit & hitAttr[A_IE];
        rspWritable <= st.rspHit & hitAttr[A_WR];
      end
      if (st.loadFar) faultAddr <= reqVa;
      if (st.loadTag) tagAccess <= {reqVa[VA_W-1:OFS_W], OFS_W'(0)} | VA_W'(reqCtx);
      if (st.setUsed) usedQ[selIdx] <= 1'b1;
      if (fillEn)     usedQ[fillIdx] <= 1'b0;
    end
  end

  assign entryUsed = usedQ;

endmodule

// File: rtl/pgcam_ctrl.sv
module pgcam_ctrl import pgcam_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic              reqUser,
  input  logic [1:0]        reqCtxType,
  input  logic              fsrClear,
  input  logic              hitAny,
  input  logic [ATTR_W-1:0] hitAttr,
  output strobe_t           st,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic              rspFault,
  output logic              rspProt,
  output logic [STAT_W-1:0] faultStatus
);

  logic isNf, isStore;
  logic ftPriv, ftSe, ftNfo, anyFt, protErr;
  logic goHit, goMiss, goFault, goProt;
  logic [STAT_W-1:0] statusQ;

  assign isNf    = (reqKind == KIND_NFLOAD);
  assign isStore = (reqKind == KIND_STORE);

  // fault causes collected together, not prioritised against each other
  assign ftPriv  = hitAttr[A_PRIV] & reqUser;
  assign ftSe    = hitAttr[A_SE]   & isNf;
  assign ftNfo   = hitAttr[A_NFO]  & ~isNf;
  assign anyFt   = hitAny & (ftPriv | ftSe | ftNfo);
  assign protErr = hitAny & ~anyFt & isStore & ~hitAttr[A_WR];

  assign goMiss  = reqValid & ~hitAny;
  assign goFault = reqValid & anyFt;
  assign goProt  = reqValid & protErr;
  assign goHit   = reqValid & hitAny & ~anyFt & ~protErr;

  always_comb begin
    st         = '0;
    st.capture = reqValid;
    st.rspHit  = goHit;
    st.setUsed = goHit;
    st.loadFar = goFault | goProt;
    st.loadTag = goMiss | goFault | goProt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspMiss  <= 1'b0;
      rspFault <= 1'b0;
      rspProt  <= 1'b0;
      statusQ  <= '0;
    end else begin
      rspValid <= reqValid;
      rspHit   <= goHit;
      rspMiss  <= goMiss;
      rspFault <= goFault;
      rspProt  <= goProt;
      if (goFault | goProt) begin
        statusQ <= {ftNfo & anyFt, ftSe & anyFt, ftPriv & anyFt,
                    reqCtxType, ~reqUser, isStore, statusQ[0], 1'b1};
      end else if (fsrClear) begin
        statusQ <= '0;
      end
    end
  end

  assign faultStatus = statusQ;

endmodule

// File: rtl/pgcam_tlb.sv
module pgcam_tlb import pgcam_pkg::*; #(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 64,
  parameter int PA_W    = 41,
  parameter int CTX_W   = 13,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillEn,
  input  logic [IDX_W-1:0]   fillIdx,
  input  logic [VA_W-1:0]    fillVa,
  input  logic [CTX_W-1:0]   fillCtx,
  input  logic [PA_W-1:0]    fillPa,
  input  logic [1:0]         fillSize,
  input  logic [6:0]         fillAttr,
  input  logic               reqValid,
  input  logic [VA_W-1:0]    reqVa,
  input  logic [CTX_W-1:0]   reqCtx,
  input  logic [1:0]         reqKind,
  input  logic               reqUser,
  input  logic [1:0]         reqCtxType,
  input  logic               fsrClear,
  output logic               rspValid,
  output logic               rspHit,
  output logic               rspMiss,
  output logic               rspFault,
  output logic               rspProt,
  output logic [PA_W-1:0]    rspPa,
  output logic               rspSwap,
  output logic               rspWritable,
  output logic [8:0]         faultStatus,
  output logic [VA_W-1:0]    faultAddr,
  output logic [VA_W-1:0]    tagAccess,
  output logic [ENTRIES-1:0] entryUsed
);

  strobe_t           st;
  logic              hitAny;
  logic [ATTR_W-1:0] hitAttr;

  pgcam_dpath #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W)) i_dpath (
    .clk(clk), .rstN(rstN),
    .fillEn(fillEn), .fillIdx(fillIdx), .fillVa(fillVa), .fillCtx(fillCtx),
    .fillPa(fillPa), .fillSize(fillSize), .fillAttr(fillAttr),
    .reqVa(reqVa), .reqCtx(reqCtx), .st(st),
    .hitAny(hitAny), .hitAttr(hitAttr),
    .rspPa(rspPa), .rspSwap(rspSwap), .rspWritable(rspWritable),
    .faultAddr(faultAddr), .tagAccess(tagAccess), .entryUsed(entryUsed)
  );

  pgcam_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqKind(reqKind), .reqUser(reqUser),
    .reqCtxType(reqCtxType), .fsrClear(fsrClear),
    .hitAny(hitAny), .hitAttr(hitAttr), .st(st),
    .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss),
    .rspFault(rspFault), .rspProt(rspProt), .faultStatus(faultStatus)
  );

endmodule

// File: rtl/pgcam_chk.sv
module pgcam_chk #(
  parameter int VA_W  = 64,
  parameter int PA_W  = 41,
  parameter int CTX_W = 13
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [CTX_W-1:0] reqCtx,
  input logic             fsrClear,
  input logic             rspValid,
  input logic             rspHit,
  input logic             rspMiss,
  input logic             rspFault,
  input logic             rspProt,
  input logic [PA_W-1:0]  rspPa,
  input logic [8:0]       faultStatus,
  input logic [VA_W-1:0]  tagAccess
);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $countones({rspHit, rspMiss, rspFault, rspProt}) == 1); // R1

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid)); // R1

  AST_PA_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspPa[12:0] == 13'd0); // R4

  AST_OVERFLOW_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspFault || rspProt)) |-> (faultStatus[1] == $past(faultStatus[0]))); // R9

  AST_FAULT_SETS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspFault || rspProt)) |-> faultStatus[0]); // R9

  AST_MISS_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspMiss && !$past(fsrClear)) |-> $stable(faultStatus)); // R10

  AST_TAG_CTX: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (tagAccess[CTX_W-1:0] == $past(reqCtx))); // R10

endmodule

bind pgcam_tlb pgcam_chk #(.VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W)) i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCtx(reqCtx),
  .fsrClear(fsrClear), .rspValid(rspValid), .rspHit(rspHit),
  .rspMiss(rspMiss), .rspFault(rspFault), .rspProt(rspProt),
  .rspPa(rspPa), .faultStatus(faultStatus), .tagAccess(tagAccess)
);

// File: tb/test_pgcam_tlb.sv
module test_pgcam_tlb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fillEn = 1'b0;
  logic [5:0]  fillIdx = '0;
  logic [63:0] fillVa = '0;
  logic [12:0] fillCtx = '0;
  logic [40:0] fillPa = '0;
  logic [1:0]  fillSize = '0;
  logic [6:0]  fillAttr = '0;
  logic        reqValid = 1'b0;
  logic [63:0] reqVa = '0;
  logic [12:0] reqCtx = '0;
  logic [1:0]  reqKind = '0;
  logic        reqUser = 1'b0;
  logic [1:0]  reqCtxType = '0;
  logic        fsrClear = 1'b0;
  logic        rspValid, rspHit, rspMiss, rspFault, rspProt, rspSwap, rspWritable;
  logic [40:0] rspPa;
  logic [8:0]  faultStatus;
  logic [63:0] faultAddr, tagAccess;
  logic [63:0] entryUsed;

  pgcam_tlb i_pgcam_tlb (.*);

  always #10 clk = ~clk;  // 50 MHz

  typedef struct packed {
    logic hit, miss, fault, prot;
    logic [40:0] pa;
    logic swap, wr;
    logic [8:0] status;
    logic [63:0] far, tag;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 1'b0;

  // reference state built from the requirements
  logic [63:0] mTag [64];
  logic [12:0] mCtx [64];
  logic [40:0] mPa  [64];
  logic [1:0]  mSz  [64];
  logic [6:0]  mAttr[64];
  logic [63:0] mUsed = '0;
  logic [8:0]  mStatus = '0;
  logic [63:0] mFar = '0, mTagAcc = '0;

  localparam logic [6:0] V = 7'd1, G = 7'd2, P = 7'd4, W = 7'd8,
                         SE = 7'd16, NFO = 7'd32, IE = 7'd64;

  task automatic check(input bit ok, input string what, input logic [255:0] act, input logic [255:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", what, act, expv);
    end
  endtask

  task automatic fill(input int idx, input logic [63:0] va, input logic [12:0] ctx,
                      input logic [40:0] pa, input logic [1:0] sz, input logic [6:0] attr);
    fillEn = 1'b1; fillIdx = 6'(idx); fillVa = va; fillCtx = ctx;
    fillPa = pa; fillSize = sz; fillAttr = attr;
    mTag[idx] = va; mCtx[idx] = ctx; mPa[idx] = pa; mSz[idx] = sz; mAttr[idx] = attr;
    mUsed[idx] = 1'b0;
    @(negedge clk);
    fillEn = 1'b0;
  endtask

  task automatic lookup(input logic [63:0] va, input logic [12:0] ctx, input logic [1:0] kind,
                        input logic user, input logic [1:0] ct, input string tg);
    exp_t e;
    int idx;
    logic [63:0] m;
    logic fp, fs, fn;
    idx = -1;
    for (int i = 0; i < 64; i++) begin
      m = ~((64'd1 << (13 + 3 * int'(mSz[i]))) - 64'd1);
      if (idx < 0 && mAttr[i][0] && (mAttr[i][1] || mCtx[i] == ctx) && ((va & m) == (mTag[i] & m)))
        idx = i;
    end
    e = '0;
    if (idx < 0) begin
      e.miss = 1'b1;
      mTagAcc = {va[63:13], 13'd0} | {51'd0, ctx};
    end else begin
      m  = ~((64'd1 << (13 + 3 * int'(mSz[idx]))) - 64'd1);
      fp = mAttr[idx][2] & user;
      fs = mAttr[idx][4] & (kind == 2'd2);
      fn = mAttr[idx][5] & (kind != 2'd2);
      if (fp | fs | fn || (kind == 2'd1 && !mAttr[idx][3])) begin
        if (fp | fs | fn) e.fault = 1'b1; else e.prot = 1'b1;
        mStatus = {fn, fs, fp, ct, ~user, kind == 2'd1, mStatus[0], 1'b1};
        mFar    = va;
        mTagAcc = {va[63:13], 13'd0} | {51'd0, ctx};
      end else begin
        e.hit  = 1'b1;
        e.pa   = ((mPa[idx] & m[40:0]) | (va[40:0] & ~m[40:0])) & ~41'h1FFF;
        e.swap = mAttr[idx][6];
        e.wr   = mAttr[idx][3];
        mUsed[idx] = 1'b1;
      end
    end
    e.status = mStatus; e.far = mFar; e.tag = mTagAcc;
    expQ.push_back(e);
    tagQ.push_back(tg);
    reqValid = 1'b1; reqVa = va; reqCtx = ctx; reqKind = kind; reqUser = user; reqCtxType = ct;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic clearStatus();
    fsrClear = 1'b1; mStatus = '0;
    @(negedge clk);
    fsrClear = 1'b0;
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
  endtask

  // monitor: compare each registered result with the oldest expectation
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      exp_t a, e;
      string tg;
      a = {rspHit, rspMiss, rspFault, rspProt, rspPa, rspSwap, rspWritable,
           faultStatus, faultAddr, tagAccess};
      if (expQ.size() == 0) begin
        check(1'b0, "R1 response with no request", 256'(a), 256'(0));
      end else begin
        e  = expQ.pop_front();
        tg = tagQ.pop_front();
        check(a == e, tg, 256'(a), 256'(e));
      end
    end
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finishRun();
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mTag[i] = '0; mCtx[i] = '0; mPa[i] = '0; mSz[i] = '0; mAttr[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!rspValid && faultStatus == 9'd0 && entryUsed == 64'd0, "R1 reset state",
          256'({rspValid, faultStatus, entryUsed}), 256'(0));

    // R12: empty buffer misses; R10 tag-access load
    lookup(64'h0000_0012_3456_7000, 13'd5, 2'd0, 1'b0, 2'd0, "R12 R10 miss on empty");
    fill(0, 64'h0000_0012_3456_6000, 13'd5, 41'h0_ABCD_E000, 2'd0, V | W);
    lookup(64'h0000_0012_3456_7ABC, 13'd5, 2'd0, 1'b0, 2'd0, "R2 R4 8K hit");
    lookup(64'h0000_0012_3456_7ABC, 13'd6, 2'd0, 1'b0, 2'd0, "R3 foreign ctx miss");
    lookup(64'h0000_0012_3456_8000, 13'd5, 2'd0, 1'b0, 2'd0, "R2 8K next page miss");
    // R3 global, R2 64K
    fill(1, 64'hFFFF_8000_0001_0000, 13'd99, 41'h1FF_0000_0000, 2'd1, V | G | W);
    lookup(64'hFFFF_8000_0001_E123, 13'd7, 2'd0, 1'b0, 2'd0, "R3 global any ctx");
    lookup(64'hFFFF_8000_0002_0000, 13'd7, 2'd0, 1'b0, 2'd0, "R2 64K boundary miss");
    // R2 512K with invert-endian, R11
    fill(2, 64'h0000_0040_0008_0000, 13'd1, 41'h055_5558_0000, 2'd2, V | W | IE);
    lookup(64'h0000_0040_000F_F000, 13'd1, 2'd0, 1'b0, 2'd0, "R2 R11 512K swap hit");
    lookup(64'h0000_0040_0010_0000, 13'd1, 2'd0, 1'b0, 2'd0, "R2 512K boundary miss");
    // R2 4M read-only, R8
    fill(3, 64'h0000_7F00_0040_0000, 13'd1, 41'h123_4540_0000, 2'd3, V);
    lookup(64'h0000_7F00_007F_E000, 13'd1, 2'd0, 1'b0, 2'd1, "R2 4M hit");
    lookup(64'h0000_7F00_007F_E000, 13'd1, 2'd1, 1'b0, 2'd1, "R8 store to read-only");
    clearStatus();
    // R4 truncation with a fully set frame
    fill(4, 64'h1234_5678_9ABC_0000, 13'd2, 41'h1FF_FFFF_FFFF, 2'd1, V | W);
    lookup(64'h1234_5678_9ABC_F321, 13'd2, 2'd0, 1'b0, 2'd0, "R4 41-bit truncation");
    // R5 lowest index wins
    fill(9, 64'h0000_0000_0ABC_0000, 13'd3, 41'h000_1111_0000, 2'd0, V);
    fill(6, 64'h0000_0000_0ABC_0000, 13'd3, 41'h000_2222_0000, 2'd0, V | G);
    lookup(64'h0000_0000_0ABC_0010, 13'd3, 2'd0, 1'b0, 2'd0, "R5 lowest index");
    // R6 privilege, R9 overflow and clear
    fill(10, 64'h0000_0000_1000_0000, 13'd4, 41'h000_3333_0000, 2'd0, V | P | W);
    lookup(64'h0000_0000_1000_0040, 13'd4, 2'd0, 1'b1, 2'd2, "R6 user to priv page");
    lookup(64'h0000_0000_1000_0040, 13'd4, 2'd1, 1'b0, 2'd0, "R6 supervisor store hit");
    lookup(64'h0000_0000_1000_1000, 13'd4, 2'd1, 1'b1, 2'd1, "R9 overflow on second fault");
    clearStatus();
    lookup(64'h0000_0000_1000_0040, 13'd4, 2'd0, 1'b1, 2'd0, "R9 no overflow after clear");
    clearStatus();
    // R7 side-effect and no-fault-only, combined causes
    fill(11, 64'h0000_0000_2000_0000, 13'd4, 41'h000_4444_0000, 2'd0, V | SE);
    lookup(64'h0000_0000_2000_0000, 13'd4, 2'd2, 1'b0, 2'd0, "R7 nf load to side-effect");
    clearStatus();
    lookup(64'h0000_0000_2000_0000, 13'd4, 2'd0, 1'b0, 2'd0, "R7 normal load side-effect ok");
    fill(12, 64'h0000_0000_3000_0000, 13'd4, 41'h000_5555_0000, 2'd0, V | NFO);
    lookup(64'h0000_0000_3000_0000, 13'd4, 2'd0, 1'b0, 2'd0, "R7 normal load to nfo");
    clearStatus();
    lookup(64'h0000_0000_3000_0000, 13'd4, 2'd2, 1'b0, 2'd0, "R7 nf load to nfo ok");
    fill(13, 64'h0000_0000_4000_0000, 13'd4, 41'h000_6666_0000, 2'd0, V | P | SE | NFO);
    lookup(64'h0000_0000_4000_0000, 13'd4, 2'd2, 1'b1, 2'd3, "R7 priv+se together");
    clearStatus();
    lookup(64'h0000_0000_4000_0000, 13'd4, 2'd1, 1'b1, 2'd2, "R7 R8 priv+nfo beats prot");
    clearStatus();
    // R11 writable flag, R12 invalid slot
    lookup(64'h0000_0012_3456_6000, 13'd5, 2'd1, 1'b1, 2'd0, "R11 writable store hit");
    fill(14, 64'h0000_0000_5000_0000, 13'd4, 41'h000_7777_0000, 2'd0, W);
    lookup(64'h0000_0000_5000_0000, 13'd4, 2'd0, 1'b0, 2'd0, "R12 invalid slot miss");
    drain();
    check(!rspValid, "R1 idle no response", 256'(rspValid), 256'(0));
    check(entryUsed == mUsed, "R11 used bits", 256'(entryUsed), 256'(mUsed));
    check(entryUsed[6] && !entryUsed[9], "R5 used on winner only",
          256'({entryUsed[6], entryUsed[9]}), 256'(2'b10));
    fill(0, 64'h0000_0012_3456_6000, 13'd5, 41'h0_ABCD_E000, 2'd0, V | W);
    drain();
    check(entryUsed == mUsed && !entryUsed[0], "R11 R12 refill clears used",
          256'(entryUsed), 256'(mUsed));
    drain();
    check(expQ.size() == 0, "R1 all results returned", 256'(expQ.size()), 256'(0));
    done = 1'b1;
    finishRun();
  end

endmodule